// File: doc/BRIEF.md
# Flash Write-Protection and Command Admission

This block sits between the serial command front-end of a flash device and its program/erase engine. Each completed command frame arrives as one transfer on a valid/ready input stream. A transfer carries a command class, the number of serial clock pulses counted while the device was selected, a target address and, for a status write, the new protection settings. The block returns a verdict for every frame on a valid/ready output stream. The verdict says whether the frame may run and, if it may not, why.

The block holds the protection state: the write-enable latch, a three-bit block-protect level and a status-lock bit. Four checks decide admission. The frame must be a whole number of bytes. The write-enable latch must be set. The target must lie outside the protected upper part of the array. A status write must not be blocked by the status-lock bit while the write-protect pin is low. A status write that is admitted updates the protection settings in the same cycle as its verdict. The engine pulses `op_done` when an admitted operation finishes.

Back-pressure works as follows. `cmd_ready` is high when no verdict is waiting, or when the waiting verdict is being taken in the same cycle. A frame is consumed on a cycle where `cmd_valid` and `cmd_ready` are both high, and its verdict appears on the next cycle. A verdict stays valid and unchanged until `vd_ready` is high. Control inputs (`wp_n`, `op_done`) and the status outputs are plain level signals.

Top module: `wpa_admission`

## Requirements
- R1: After reset the write-enable latch is 0, the protect level equals `BP_RESET`, the status-lock bit equals `SRWD_RESET`, `vd_valid` is 0 and `cmd_ready` is 1.
- R2: A frame is consumed when `cmd_valid` and `cmd_ready` are both high, and its verdict appears one cycle later. `cmd_ready` is low while a verdict is pending and `vd_ready` is low. A pending verdict keeps its fields stable until it is taken. A frame held during a stall is not consumed.
- R3: Class codes are 0 read, 1 write-enable, 2 write-disable, 3 status write, 4 program, 5 sector erase, 6 bulk erase; code 7 behaves as a read. A write-enable frame of exactly 8 bits is accepted and sets the latch. A write-disable frame of exactly 8 bits is accepted and clears it. Any other bit count for either class is rejected with reason FRAME.
- R4: A modifying frame (class 3 to 6) that arrives while the latch is 0 is rejected with reason NO_WEL. Reason codes are 0 OK, 1 FRAME, 2 NO_WEL, 3 LOCKED, 4 PROTECT.
- R5: A modifying frame whose bit count is zero or not a multiple of 8 is rejected with reason FRAME.
- R6: The sector is the top 6 address bits. For a program or sector erase, protect level 0 protects no sector, level 7 protects all sectors, and level n from 1 to 6 protects sectors 64-2^(n-1) to 63. A target inside the protected range is rejected with reason PROTECT.
- R7: A bulk erase is rejected with reason PROTECT unless the protect level is 0.
- R8: A status write carries `cmd_sr_wdata` = {lock bit, level[2:0]}. If it is accepted, it loads these values. While `wp_n` is 0 and the lock bit is 1, a status write is rejected with reason LOCKED and the protect level and lock bit do not change.
- R9: Any rejected frame clears the write-enable latch. An `op_done` pulse clears it, unless an accepted write-enable is consumed in the same cycle.
- R10: A read-class frame is always accepted whatever its bit count, and leaves the latch and the protection settings unchanged.
- R11: When a frame fails several checks, the reported reason is chosen in the order FRAME, then NO_WEL, then LOCKED or PROTECT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_n | input | 1 | Write-protect pin, low asserts the hardware lock |
| cmd_valid | input | 1 | Command frame valid |
| cmd_ready | output | 1 | Block can consume a frame |
| cmd_class | input | 3 | Command class code |
| cmd_bits | input | BITS_W | Serial clock pulses seen in the frame |
| cmd_addr | input | ADDR_W | Target address |
| cmd_sr_wdata | input | 4 | Status write payload {lock, level} |
| op_done | input | 1 | Engine finished an admitted operation |
| vd_valid | output | 1 | Verdict valid |
| vd_ready | input | 1 | Engine takes the verdict |
| vd_accept | output | 1 | Frame may run |
| vd_reason | output | 3 | Reason code |
| vd_class | output | 3 | Class of the judged frame |
| vd_addr | output | ADDR_W | Address of the judged frame |
| sr_wel | output | 1 | Write-enable latch |
| sr_bp | output | 3 | Block-protect level |
| sr_srwd | output | 1 | Status-lock bit |

## Verification
The bench sweeps every protect level against every sector for both program and sector erase, so that a design with the range edge off by one sector, or with levels 1 and 7 confused, fails at the boundary sector. A sweep of bit counts from 0 to 40 catches a framing check that tests only the low bits and lets a zero count through. The lock matrix over `wp_n` and the lock bit catches a design that ignores the pin, or that still lets the level change while locked. A stall test with `vd_ready` held low catches a design that drops a frame or overwrites a pending verdict. Failed-check paths confirm that the latch is cleared, which catches a design that leaves write permission open after a reject.

// File: rtl/wpa_pkg.sv
package wpa_pkg;

  typedef enum logic [2:0] {
    CLS_READ   = 3'd0,
    CLS_WREN   = 3'd1,
    CLS_WRDI   = 3'd2,
    CLS_WRSR   = 3'd3,
    CLS_PROG   = 3'd4,
    CLS_SERASE = 3'd5,
    CLS_BERASE = 3'd6
  } cmd_class_e;

  typedef enum logic [2:0] {
    RSN_OK      = 3'd0,
    RSN_FRAME   = 3'd1,
    RSN_NO_WEL  = 3'd2,
    RSN_LOCKED  = 3'd3,
    RSN_PROTECT = 3'd4
  } reason_e;

  typedef struct packed {
    logic       srwd;
    logic [2:0] bp;
  } prot_cfg_t;

endpackage

// File: rtl/wpa_frame_check.sv
module wpa_frame_check #(
  parameter int BITS_W = 12
) (
  input  logic [BITS_W-1:0] bits,
  output logic              whole_bytes,
  output logic              single_byte
);
  localparam logic [BITS_W-1:0] ONE_BYTE = BITS_W'(8);

  // Whole bytes means a non-zero count with the three low bits clear.
  assign whole_bytes = (bits != '0) && (bits[2:0] == 3'b000);
  assign single_byte = (bits == ONE_BYTE);
endmodule

// File: rtl/wpa_protect_decode.sv
module wpa_protect_decode #(
  parameter int ADDR_W = 24,
  parameter int SECT_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        bp,
  output logic              hit
);
  localparam logic [SECT_W:0] NSECT = (SECT_W+1)'(1) << SECT_W;

  logic [SECT_W-1:0] sector;
  logic [SECT_W:0]   span;
  logic [SECT_W:0]   first_prot;

  assign sector = addr[ADDR_W-1 -: SECT_W];

  always_comb begin
    span       = (SECT_W+1)'(1) << (bp - 3'd1);
    first_prot = NSECT - span;
    case (bp)
      3'd0:    hit = 1'b0;
      3'd7:    hit = 1'b1;
      default: hit = ({1'b0, sector} >= first_prot);
    endcase
  end
endmodule

// File: rtl/wpa_status_reg.sv
module wpa_status_reg
  import wpa_pkg::*;
#(
  parameter logic [2:0] BP_RESET   = 3'b000,
  parameter logic       SRWD_RESET = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wp_n,
  input  logic      set_wel,
  input  logic      clr_wel,
  input  logic      wr_cfg_en,
  input  prot_cfg_t wr_cfg,
  output logic      wel,
  output prot_cfg_t cfg
);
  logic locked;
  assign locked = cfg.srwd && !wp_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wel      <= 1'b0;
      cfg.bp   <= BP_RESET;
      cfg.srwd <= SRWD_RESET;
    end else begin
      if (set_wel)      wel <= 1'b1;
      else if (clr_wel) wel <= 1'b0;
      if (wr_cfg_en && !locked) cfg <= wr_cfg;
    end
  end

  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.srwd && !wp_n) |=> ($stable(cfg.bp) && cfg.srwd)); // R8
  AST_WEL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wel && !set_wel) |=> !wel); // R9
endmodule

// File: rtl/wpa_admission.sv
module wpa_admission
  import wpa_pkg::*;
#(
  parameter int         ADDR_W     = 24,
  parameter int         SECT_W     = 6,
  parameter int         BITS_W     = 12,
  parameter logic [2:0] BP_RESET   = 3'b000,
  parameter logic       SRWD_RESET = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_class,
  input  logic [BITS_W-1:0] cmd_bits,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [3:0]        cmd_sr_wdata,
  input  logic              op_done,
  output logic              vd_valid,
  input  logic              vd_ready,
  output logic              vd_accept,
  output logic [2:0]        vd_reason,
  output logic [2:0]        vd_class,
  output logic [ADDR_W-1:0] vd_addr,
  output logic              sr_wel,
  output logic [2:0]        sr_bp,
  output logic              sr_srwd
);
  logic      fire, whole_bytes, single_byte, prot_hit, is_mod, locked;
  logic      acc, set_wel, clr_wel, wr_cfg_en;
  reason_e   rsn;
  prot_cfg_t cfg, wr_cfg;
  logic      wel;

  assign cmd_ready = !vd_valid || vd_ready;
  assign fire      = cmd_valid && cmd_ready;
  assign is_mod    = (cmd_class == CLS_WRSR) || (cmd_class == CLS_PROG) ||
                     (cmd_class == CLS_SERASE) || (cmd_class == CLS_BERASE);
  assign locked    = cfg.srwd && !wp_n;
  assign wr_cfg    = prot_cfg_t'(cmd_sr_wdata);

  wpa_frame_check #(.BITS_W(BITS_W)) u_frame (
    .bits        (cmd_bits),
    .whole_bytes (whole_bytes),
    .single_byte (single_byte)
  );

  wpa_protect_decode #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_decode (
    .addr (cmd_addr),
    .bp   (cfg.bp),
    .hit  (prot_hit)
  );

  // Checks in priority order: framing, latch, then lock or range.
  always_comb begin
    rsn = RSN_OK;
    case (cmd_class)
      CLS_WREN, CLS_WRDI: begin
        if (!single_byte) rsn = RSN_FRAME;
      end
      CLS_WRSR: begin
        if (!whole_bytes) rsn = RSN_FRAME;
        else if (!wel)    rsn = RSN_NO_WEL;
        else if (locked)  rsn = RSN_LOCKED;
      end
      CLS_PROG, CLS_SERASE: begin
        if (!whole_bytes)  rsn = RSN_FRAME;
        else if (!wel)     rsn = RSN_NO_WEL;
        else if (prot_hit) rsn = RSN_PROTECT;
      end
      CLS_BERASE: begin
        if (!whole_bytes)         rsn = RSN_FRAME;
        else if (!wel)            rsn = RSN_NO_WEL;
        else if (cfg.bp != 3'd0)  rsn = RSN_PROTECT;
      end
      default: rsn = RSN_OK;
    endcase
    acc = (rsn == RSN_OK);
  end

  assign set_wel   = fire && acc && (cmd_class == CLS_WREN);
  assign clr_wel   = op_done || (fire && (!acc || (cmd_class == CLS_WRDI)));
  assign wr_cfg_en = fire && acc && (cmd_class == CLS_WRSR);

  wpa_status_reg #(.BP_RESET(BP_RESET), .SRWD_RESET(SRWD_RESET)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .wp_n      (wp_n),
    .set_wel   (set_wel),
    .clr_wel   (clr_wel),
    .wr_cfg_en (wr_cfg_en),
    .wr_cfg    (wr_cfg),
    .wel       (wel),
    .cfg       (cfg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vd_valid  <= 1'b0;
      vd_accept <= 1'b0;
      vd_reason <= RSN_OK;
      vd_class  <= CLS_READ;
      vd_addr   <= '0;
    end else if (fire) begin
      vd_valid  <= 1'b1;
      vd_accept <= acc;
      vd_reason <= rsn;
      vd_class  <= cmd_class;
      vd_addr   <= cmd_addr;
    end else if (vd_ready) begin
      vd_valid  <= 1'b0;
    end
  end

  assign sr_wel  = wel;
  assign sr_bp   = cfg.bp;
  assign sr_srwd = cfg.srwd;

  AST_VD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vd_valid && !vd_ready) |=> (vd_valid && $stable(vd_accept) && $stable(vd_reason) && $stable(vd_class))); // R2
  AST_FRAME_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_mod && !whole_bytes) |=> (vd_valid && !vd_accept && vd_reason == RSN_FRAME)); // R5
  AST_NEED_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_mod && !sr_wel) |=> !vd_accept); // R4
  AST_BULK_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_class == CLS_BERASE && sr_bp != 3'd0) |=> !vd_accept); // R7
endmodule

// File: tb/wpa_admission_tb.sv
`timescale 1ns/1ps
module wpa_admission_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_n = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [2:0] cmd_class = 3'd0;
  logic [11:0] cmd_bits = '0;
  logic [23:0] cmd_addr = '0;
  logic [3:0] cmd_sr_wdata = '0;
  logic op_done = 1'b0;
  logic vd_valid, vd_accept, sr_wel, sr_srwd;
  logic vd_ready = 1'b1;
  logic [2:0] vd_reason, vd_class, sr_bp;
  logic [23:0] vd_addr;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  wpa_admission u_dut (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_class(cmd_class),
    .cmd_bits(cmd_bits), .cmd_addr(cmd_addr), .cmd_sr_wdata(cmd_sr_wdata),
    .op_done(op_done), .vd_valid(vd_valid), .vd_ready(vd_ready),
    .vd_accept(vd_accept), .vd_reason(vd_reason), .vd_class(vd_class),
    .vd_addr(vd_addr), .sr_wel(sr_wel), .sr_bp(sr_bp), .sr_srwd(sr_srwd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input int c, input int bits, input int a, input int d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_class = 3'(c); cmd_bits = 12'(bits);
    cmd_addr = 24'(a); cmd_sr_wdata = 4'(d);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic verdict(input string req, input int acc, input int rsn);
    chk(vd_valid == 1'b1, req, int'(vd_valid), 1);
    chk(vd_accept == acc[0], req, int'(vd_accept), acc);
    chk(int'(vd_reason) == rsn, req, int'(vd_reason), rsn);
  endtask

  task automatic set_cfg(input int d);
    issue(1, 8, 0, 0);
    issue(3, 16, 0, d);
  endtask

  function automatic int exp_prot(input int bp, input int s);
    if (bp == 0) return 0;
    if (bp == 7) return 1;
    return (s >= 64 - (1 << (bp - 1))) ? 1 : 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sr_wel == 0, "R1 wel", int'(sr_wel), 0);
    chk(sr_bp == 0, "R1 bp", int'(sr_bp), 0);
    chk(sr_srwd == 0, "R1 srwd", int'(sr_srwd), 0);
    chk(vd_valid == 0, "R1 vd_valid", int'(vd_valid), 0);
    chk(cmd_ready == 1, "R1 ready", int'(cmd_ready), 1);
    rst_n = 1'b1;

    // R10 read always accepted, no state change
    for (int b = 1; b < 12; b += 5) begin
      issue(0, b, 0, 0);
      verdict("R10 read", 1, 0);
      chk(sr_wel == 0, "R10 wel", int'(sr_wel), 0);
    end
    issue(7, 3, 0, 0);
    verdict("R10 code7", 1, 0);

    // R3 write enable / disable
    issue(1, 8, 0, 0);
    verdict("R3 wren", 1, 0);
    chk(sr_wel == 1, "R3 wel set", int'(sr_wel), 1);
    issue(0, 8, 0, 0);
    chk(sr_wel == 1, "R10 read keeps wel", int'(sr_wel), 1);
    issue(2, 8, 0, 0);
    verdict("R3 wrdi", 1, 0);
    chk(sr_wel == 0, "R3 wel clr", int'(sr_wel), 0);
    issue(1, 16, 0, 0);
    verdict("R3 wren bad len", 0, 1);
    chk(sr_wel == 0, "R3 wel stays", int'(sr_wel), 0);
    issue(1, 8, 0, 0);
    issue(2, 7, 0, 0);
    verdict("R3 wrdi bad len", 0, 1);
    chk(sr_wel == 0, "R9 reject clears", int'(sr_wel), 0);

    // R4 no latch
    for (int c = 3; c <= 6; c++) begin
      issue(c, 32, 0, 0);
      verdict("R4 no wel", 0, 2);
    end
    // R11 framing wins over missing latch
    issue(4, 13, 0, 0);
    verdict("R11 frame before wel", 0, 1);

    // R5 bit count sweep
    for (int b = 0; b <= 40; b++) begin
      int ok;
      ok = (b > 0 && b % 8 == 0) ? 1 : 0;
      issue(1, 8, 0, 0);
      issue(4, b, 24'h000100, 0);
      verdict("R5 frame", ok, ok ? 0 : 1);
      chk(sr_wel == ok[0], "R9 wel after", int'(sr_wel), ok);
      if (ok != 0) begin
        @(negedge clk); op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
        chk(sr_wel == 0, "R9 op_done", int'(sr_wel), 0);
      end
    end

    // R6 / R7 protect sweep
    for (int bp = 0; bp < 8; bp++) begin
      set_cfg(bp);
      chk(int'(sr_bp) == bp, "R8 bp load", int'(sr_bp), bp);
      for (int s = 0; s < 64; s++) begin
        for (int c = 4; c <= 5; c++) begin
          int p;
          p = exp_prot(bp, s);
          issue(1, 8, 0, 0);
          issue(c, 32, (s << 18) | ((s * 1237) & 24'h3FFFF), 0);
          verdict("R6 range", 1 - p, p ? 4 : 0);
          if (p == 0) begin
            issue(2, 8, 0, 0);
          end
        end
      end
      issue(1, 8, 0, 0);
      issue(6, 8, 0, 0);
      verdict("R7 bulk", bp == 0 ? 1 : 0, bp == 0 ? 0 : 4);
      issue(2, 8, 0, 0);
    end
    // R11 framing beats range
    issue(1, 8, 0, 0);
    issue(5, 31, 24'hFC0000, 0);
    verdict("R11 frame before protect", 0, 1);

    // R8 lock matrix
    set_cfg(8 | 3);
    chk(sr_srwd == 1 && sr_bp == 3, "R8 load lock", int'(sr_bp), 3);
    wp_n = 1'b0;
    issue(1, 8, 0, 0);
    issue(3, 16, 0, 0);
    verdict("R8 locked", 0, 3);
    chk(sr_bp == 3, "R8 bp frozen", int'(sr_bp), 3);
    chk(sr_srwd == 1, "R8 srwd frozen", int'(sr_srwd), 1);
    chk(sr_wel == 0, "R9 lock clears", int'(sr_wel), 0);
    wp_n = 1'b1;
    set_cfg(0);
    verdict("R8 unlocked", 1, 0);
    chk(sr_bp == 0 && sr_srwd == 0, "R8 cleared", int'(sr_bp), 0);
    wp_n = 1'b0;
    set_cfg(5);
    verdict("R8 pin low no lock bit", 1, 0);
    chk(sr_bp == 5, "R8 bp5", int'(sr_bp), 5);
    wp_n = 1'b1;

    // R9 op_done vs same-cycle write enable
    @(negedge clk);
    cmd_valid = 1'b1; cmd_class = 3'd1; cmd_bits = 12'd8; op_done = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; op_done = 1'b0;
    chk(sr_wel == 1, "R9 wren beats op_done", int'(sr_wel), 1);
    issue(2, 8, 0, 0);

    // R2 stall
    @(negedge clk);
    vd_ready = 1'b0;
    cmd_valid = 1'b1; cmd_class = 3'd0; cmd_bits = 12'd8; cmd_addr = 24'h123456;
    @(negedge clk);
    cmd_class = 3'd1; cmd_addr = 24'h000000;
    chk(cmd_ready == 0, "R2 ready low", int'(cmd_ready), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(vd_valid == 1 && vd_class == 3'd0, "R2 hold class", int'(vd_class), 0);
      chk(vd_addr == 24'h123456, "R2 hold addr", int'(vd_addr), 24'h123456);
      chk(sr_wel == 0, "R2 not consumed", int'(sr_wel), 0);
    end
    vd_ready = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(vd_valid == 1 && vd_class == 3'd1, "R2 next verdict", int'(vd_class), 1);
    chk(sr_wel == 1, "R2 consumed once", int'(sr_wel), 1);
    @(negedge clk);
    chk(vd_valid == 0, "R2 drained", int'(vd_valid), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule